// File: doc/BRIEF.md
# Program-Flow Sequencer

This block owns the program counter of a small 16-bit-word microcontroller core. Every cycle it looks at the instruction word fetched from the current address, decodes the control-flow group of the instruction set, and works out the next address. Four ALU status flags (carry, zero, overflow, negative) drive the conditional branches. Arithmetic, memory access and interrupt arbitration belong to other blocks. This block only issues single-cycle strobes for them: a literal load into the working register, re-enabling of interrupts, sleep entry, watchdog restart, software reset and the fast shadow save/restore selector.

Whenever the address leaves the sequential path (a taken branch, a relative branch or call, any return, or a software reset), the following slot becomes a bubble and `flush_o` marks it. In a bubble slot the fetched word is discarded and the address holds. Absolute call and jump use two words. The first word carries the low eight target bits and the second word carries the upper twelve. A word whose top nibble is 1111, reached on its own, does nothing. Return addresses go to a small hardware stack that saturates at its bounds and never wraps.

Top module: `pflow_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address is cleared to 0, `flush_o` to 0 and the return stack to empty.
- R2: A word with top bits 11100 is a conditional branch. Bits [10:8] select the condition: 000 Z, 001 not Z, 010 C, 011 not C, 100 V, 101 not V, 110 N, 111 not N. Bits [7:0] are a signed word offset. When taken, the next address is the current address + 1 + offset and the next slot is flushed. When not taken, the address advances by 1 with no flush.
- R3: Top bits 11010 give an unconditional branch and 11011 a relative call, each with an 11-bit signed offset in bits [10:0] added to the current address + 1. Both flush the next slot. The call also pushes the current address + 1.
- R4: Word 1110110s kkkkkkkk starts an absolute call and 11101111 kkkkkkkk starts an absolute jump. The next word supplies target bits [19:8] from its bits [11:0]. The pair takes exactly two cycles with no bubble. A call pushes the address following its second word, in the second-word cycle.
- R5: A word with top nibble 1111 that does not follow a call or jump first word only advances the address by 1, with no flush and no strobe.
- R6: 0x0012/0x0013 (return) and 0x0010/0x0011 (interrupt return) pop the stack, load the popped address and flush the next slot. The interrupt return also pulses `gie_set_o`.
- R7: 0x0Ckk returns like R6 and pulses `wreg_ld_o` with `wreg_val_o` = kk.
- R8: 0x0005 pushes the current address + 1 and 0x0006 discards the top entry. Each takes one cycle and advances the address by 1.
- R9: A push while the stack is full stores nothing, leaves the contents unchanged, pulses `stk_ovf_o` and keeps `push_o` low. A pop while empty yields address 0, pulses `stk_unf_o` and keeps `pop_o` low.
- R10: 0x0003 pulses `sleep_o` and 0x0004 pulses `wdt_clr_o`. Both advance the address by 1.
- R11: 0x00FF pulses `soft_rst_o`, loads address 0, empties the stack and flushes the next slot.
- R12: `fast_o` pulses with bit s set: bit 8 of the call first word (reported in the second-word cycle), or bit 0 of a return or interrupt return (reported in that cycle).
- R13: In a flushed slot the fetched word has no effect: no strobe fires and the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Word fetched from `pc_o` this cycle |
| c_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| v_i | input | 1 | Overflow flag |
| n_i | input | 1 | Negative flag |
| pc_o | output | PC_W | Current fetch address |
| flush_o | output | 1 | Current slot is a bubble |
| push_o | output | 1 | A return address was stored |
| pop_o | output | 1 | An entry was removed |
| fast_o | output | 1 | Fast shadow save/restore selector |
| gie_set_o | output | 1 | Re-enable interrupts |
| wreg_ld_o | output | 1 | Load literal into working register |
| wreg_val_o | output | 8 | Literal value |
| sleep_o | output | 1 | Enter standby |
| wdt_clr_o | output | 1 | Restart watchdog |
| soft_rst_o | output | 1 | Software reset request |
| stk_ovf_o | output | 1 | Push refused, stack full |
| stk_unf_o | output | 1 | Pop on empty stack |

## Verification
The bench builds the sequencer with a return stack of depth 4 and a 20-bit address. The shallow stack lets five pushes in a row reach the saturation and underflow paths within a few cycles. The full 20-bit width keeps the upper bits of a two-word call target visible at `pc_o`, while the bench's 256-word program memory wraps on the low address byte. Every conditional encoding runs under all sixteen flag combinations, and the bubble slot is checked to ignore a push placed at the branch target.

// File: rtl/pflow_pkg.sv
// Shared types of the program-flow sequencer.
// Assumes: 16-bit instruction words, 11-bit normalised offsets.
package pflow_pkg;

    localparam int OFF_W = 11;   // widest relative offset field
    localparam int LO_W  = 8;    // target bits in a two-word first word
    localparam int HI_W  = 12;   // target bits in a two-word second word

    typedef enum logic [3:0] {
        OP_NOP, OP_BCOND, OP_BRA, OP_RCALL, OP_CALL1, OP_GOTO1,
        OP_RET, OP_RETFIE, OP_RETLW, OP_PUSH, OP_POP,
        OP_SLEEP, OP_CLRWDT, OP_RESET
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             taken;   // condition met (conditional branch only)
        logic [OFF_W-1:0] off;     // sign-normalised word offset
        logic [LO_W-1:0]  lit;     // literal / low target bits
        logic             sbit;    // fast shadow selector
    } dec_t;

endpackage

// File: rtl/pflow_decode.sv
// Instruction classifier for the control-flow group.
// Purely combinational. Assumes the word is valid in the slot it is
// presented in; bubble and second-word handling live in the caller.
module pflow_decode
    import pflow_pkg::*;
(
    input  logic [15:0] word_i,
    input  logic        c_i,
    input  logic        z_i,
    input  logic        v_i,
    input  logic        n_i,
    output dec_t        dec_o
);

    logic flag_sel;
    logic cond_hit;

    // Pick the flag named by bits [10:9]; bit 8 inverts it.
    always_comb begin
        unique case (word_i[10:9])
            2'b00:   flag_sel = z_i;
            2'b01:   flag_sel = c_i;
            2'b10:   flag_sel = v_i;
            default: flag_sel = n_i;
        endcase
        cond_hit = flag_sel ^ word_i[8];
    end

    // Classify the word and extract its fields.
    always_comb begin
        dec_o       = '0;
        dec_o.op    = OP_NOP;
        dec_o.lit   = word_i[7:0];
        dec_o.sbit  = word_i[0];
        if (word_i[15:11] == 5'b11100) begin
            dec_o.op    = OP_BCOND;
            dec_o.taken = cond_hit;
            dec_o.off   = {{(OFF_W-8){word_i[7]}}, word_i[7:0]};
        end else if (word_i[15:9] == 7'b1110110) begin
            dec_o.op   = OP_CALL1;
            dec_o.sbit = word_i[8];
        end else if (word_i[15:8] == 8'hEF) begin
            dec_o.op = OP_GOTO1;
        end else if (word_i[15:11] == 5'b11010) begin
            dec_o.op  = OP_BRA;
            dec_o.off = word_i[10:0];
        end else if (word_i[15:11] == 5'b11011) begin
            dec_o.op  = OP_RCALL;
            dec_o.off = word_i[10:0];
        end else if (word_i[15:8] == 8'h0C) begin
            dec_o.op = OP_RETLW;
        end else begin
            unique case (word_i)
                16'h0010, 16'h0011: dec_o.op = OP_RETFIE;
                16'h0012, 16'h0013: dec_o.op = OP_RET;
                16'h0005:           dec_o.op = OP_PUSH;
                16'h0006:           dec_o.op = OP_POP;
                16'h0003:           dec_o.op = OP_SLEEP;
                16'h0004:           dec_o.op = OP_CLRWDT;
                16'h00FF:           dec_o.op = OP_RESET;
                default:            dec_o.op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/pflow_rstack.sv
// Saturating hardware return stack.
// Assumes push and pop are never requested together; DEPTH >= 2.
// A refused push or pop is flagged and leaves pointer and contents alone.
module pflow_rstack #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] din_i,
    output logic [PC_W-1:0] tos_o,
    output logic            ovf_o,
    output logic            unf_o
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0] sp_q;
    logic [PC_W-1:0] ent_q [DEPTH];
    logic            full;
    logic            empty;

    // Occupancy state and refusal flags.
    always_comb begin
        full  = (sp_q == SP_W'(DEPTH));
        empty = (sp_q == '0);
        ovf_o = push_i && full;
        unf_o = pop_i && empty;
        tos_o = empty ? '0 : ent_q[IDX_W'(sp_q - 1'b1)];
    end

    // Pointer: clear on reset, move only on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)         sp_q <= '0;
        else if (push_i && !full)    sp_q <= sp_q + 1'b1;
        else if (pop_i && !empty)    sp_q <= sp_q - 1'b1;
    end

    // Storage: write the slot above the top on an accepted push.
    always_ff @(posedge clk) begin
        if (push_i && !full) ent_q[IDX_W'(sp_q)] <= din_i;
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SP_W'(DEPTH));
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> $stable(sp_q));
    p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> (sp_q == '0));
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sp_q == '0));

endmodule

// File: rtl/pflow_seq.sv
// Program-flow sequencer: holds the fetch address, decodes the
// control-flow group, drives the return stack and issues strobes.
// Assumes instr_i is the word at pc_o in the same cycle, PC_W > 11,
// and that a two-word target is {second[11:0], first[7:0]}.
module pflow_seq
    import pflow_pkg::*;
#(
    parameter int PC_W  = 20,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     instr_i,
    input  logic            c_i,
    input  logic            z_i,
    input  logic            v_i,
    input  logic            n_i,
    output logic [PC_W-1:0] pc_o,
    output logic            flush_o,
    output logic            push_o,
    output logic            pop_o,
    output logic            fast_o,
    output logic            gie_set_o,
    output logic            wreg_ld_o,
    output logic [7:0]      wreg_val_o,
    output logic            sleep_o,
    output logic            wdt_clr_o,
    output logic            soft_rst_o,
    output logic            stk_ovf_o,
    output logic            stk_unf_o
);

    localparam int TGT_W = LO_W + HI_W;

    dec_t            dec;
    logic [PC_W-1:0] pc_q, pc_n, pc_inc, rel_tgt, abs_tgt, tos;
    logic            flush_q, flush_n, pend_q, pend_n;
    logic            call_q, call_n, s_q, s_n;
    logic [LO_W-1:0] lo_q, lo_n;
    logic            push_req, pop_req, clr_req;

    pflow_decode u_dec (
        .word_i (instr_i),
        .c_i    (c_i),
        .z_i    (z_i),
        .v_i    (v_i),
        .n_i    (n_i),
        .dec_o  (dec)
    );

    pflow_rstack #(.DEPTH(DEPTH), .PC_W(PC_W)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_req),
        .push_i (push_req),
        .pop_i  (pop_req),
        .din_i  (pc_inc),
        .tos_o  (tos),
        .ovf_o  (stk_ovf_o),
        .unf_o  (stk_unf_o)
    );

    // Candidate addresses: sequential, relative and two-word absolute.
    always_comb begin
        pc_inc  = pc_q + 1'b1;
        rel_tgt = pc_inc + {{(PC_W-OFF_W){dec.off[OFF_W-1]}}, dec.off};
        abs_tgt = PC_W'({instr_i[HI_W-1:0], lo_q});
    end

    // Next-state and strobe selection for the current slot.
    always_comb begin
        pc_n = pc_inc;  flush_n = 1'b0;  pend_n = 1'b0;
        call_n = call_q; s_n = s_q;      lo_n = lo_q;
        push_req = 1'b0; pop_req = 1'b0; clr_req = 1'b0;
        fast_o = 1'b0;   gie_set_o = 1'b0; wreg_ld_o = 1'b0;
        sleep_o = 1'b0;  wdt_clr_o = 1'b0; soft_rst_o = 1'b0;
        wreg_val_o = dec.lit;
        if (flush_q) begin
            pc_n = pc_q;
        end else if (pend_q) begin
            pc_n     = abs_tgt;
            push_req = call_q;
            fast_o   = call_q && s_q;
        end else begin
            unique case (dec.op)
                OP_BCOND: if (dec.taken) begin
                    pc_n = rel_tgt; flush_n = 1'b1;
                end
                OP_BRA: begin
                    pc_n = rel_tgt; flush_n = 1'b1;
                end
                OP_RCALL: begin
                    pc_n = rel_tgt; flush_n = 1'b1; push_req = 1'b1;
                end
                OP_CALL1: begin
                    pend_n = 1'b1; call_n = 1'b1; s_n = dec.sbit; lo_n = dec.lit;
                end
                OP_GOTO1: begin
                    pend_n = 1'b1; call_n = 1'b0; s_n = 1'b0; lo_n = dec.lit;
                end
                OP_RET: begin
                    pc_n = tos; flush_n = 1'b1; pop_req = 1'b1; fast_o = dec.sbit;
                end
                OP_RETFIE: begin
                    pc_n = tos; flush_n = 1'b1; pop_req = 1'b1; fast_o = dec.sbit;
                    gie_set_o = 1'b1;
                end
                OP_RETLW: begin
                    pc_n = tos; flush_n = 1'b1; pop_req = 1'b1; wreg_ld_o = 1'b1;
                end
                OP_PUSH:   push_req  = 1'b1;
                OP_POP:    pop_req   = 1'b1;
                OP_SLEEP:  sleep_o   = 1'b1;
                OP_CLRWDT: wdt_clr_o = 1'b1;
                OP_RESET: begin
                    pc_n = '0; flush_n = 1'b1; clr_req = 1'b1; soft_rst_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Accepted stack operations only are reported.
    always_comb begin
        push_o  = push_req && !stk_ovf_o;
        pop_o   = pop_req && !stk_unf_o;
        pc_o    = pc_q;
        flush_o = flush_q;
    end

    // Sequencer state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0; flush_q <= 1'b0; pend_q <= 1'b0;
            call_q <= 1'b0; s_q <= 1'b0; lo_q <= '0;
        end else begin
            pc_q <= pc_n; flush_q <= flush_n; pend_q <= pend_n;
            call_q <= call_n; s_q <= s_n; lo_q <= lo_n;
        end
    end

    p_taken_bubble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_q && !pend_q && dec.op == OP_BCOND && dec.taken) |=> flush_o);
    p_not_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_q && !pend_q && dec.op == OP_BCOND && !dec.taken)
        |=> (!flush_o && pc_o == $past(pc_o) + 1'b1));
    p_pend_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (!pend_q && !flush_o));
    p_bubble_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> ($stable(pc_o) && !flush_o));
    p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_o && pop_o));
    p_reset_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (pc_o == '0 && flush_o));

endmodule

// File: tb/pflow_seq_tb.sv
module pflow_seq_tb_top;

    localparam int PC_W = 20;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            c_i = 0, z_i = 0, v_i = 0, n_i = 0;
    logic [15:0]     instr_i;
    logic [PC_W-1:0] pc_o;
    logic            flush_o, push_o, pop_o, fast_o, gie_set_o, wreg_ld_o;
    logic [7:0]      wreg_val_o;
    logic            sleep_o, wdt_clr_o, soft_rst_o, stk_ovf_o, stk_unf_o;
    logic [15:0]     mem [256];
    int              nchk = 0, nfail = 0;

    always #5 clk = ~clk;
    assign instr_i = mem[pc_o[7:0]];

    pflow_seq #(.PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
        .c_i(c_i), .z_i(z_i), .v_i(v_i), .n_i(n_i),
        .pc_o(pc_o), .flush_o(flush_o), .push_o(push_o), .pop_o(pop_o),
        .fast_o(fast_o), .gie_set_o(gie_set_o), .wreg_ld_o(wreg_ld_o),
        .wreg_val_o(wreg_val_o), .sleep_o(sleep_o), .wdt_clr_o(wdt_clr_o),
        .soft_rst_o(soft_rst_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        clear_mem(); do_reset();
        check("R1 pc", 32'(pc_o), 0);
        check("R1 flush", 32'(flush_o), 0);
        check("R1 empty stack", 32'(stk_ovf_o | stk_unf_o), 0);
    endtask

    // R2/R13: every condition under every flag combination
    task automatic t_cond_all();
        for (int cnd = 0; cnd < 8; cnd++) begin
            for (int f = 0; f < 16; f++) begin
                logic exp_t;
                clear_mem();
                mem[0] = 16'hE000 | 16'(cnd << 8) | 16'h0005;
                mem[6] = 16'h0005;
                {n_i, v_i, z_i, c_i} = 4'(f);
                case (cnd)
                    0: exp_t = z_i;  1: exp_t = !z_i;
                    2: exp_t = c_i;  3: exp_t = !c_i;
                    4: exp_t = v_i;  5: exp_t = !v_i;
                    6: exp_t = n_i;  default: exp_t = !n_i;
                endcase
                do_reset();
                tick();
                if (exp_t) begin
                    check("R2 taken pc", 32'(pc_o), 6);
                    check("R2 taken flush", 32'(flush_o), 1);
                    check("R13 bubble no push", 32'(push_o), 0);
                    tick();
                    check("R13 bubble holds pc", 32'(pc_o), 6);
                    check("R2 after bubble push live", 32'(push_o), 1);
                end else begin
                    check("R2 not taken pc", 32'(pc_o), 1);
                    check("R2 not taken flush", 32'(flush_o), 0);
                end
            end
        end
        {n_i, v_i, z_i, c_i} = 4'h0;
    endtask

    // R2/R3: negative offsets of both widths
    task automatic t_neg_offsets();
        clear_mem();
        mem[0] = 16'hD00F;          // branch +15 -> 0x10
        mem[16] = 16'hE1FE;         // not-zero, -2 -> 0x0F
        mem[15] = 16'hD7FF;         // branch -1 -> 0x0F
        z_i = 0; do_reset();
        tick(); check("R3 bra fwd", 32'(pc_o), 16'h10); check("R3 bra flush", 32'(flush_o), 1);
        tick(); tick(); check("R2 neg offset", 32'(pc_o), 16'h0F);
        tick(); tick(); check("R3 bra -1 self", 32'(pc_o), 16'h0F);
        check("R3 bra -1 flush", 32'(flush_o), 1);
    endtask

    // R3/R6: relative call and plain return
    task automatic t_rcall_ret();
        clear_mem();
        mem[0] = 16'hD820; mem[33] = 16'h0012;
        do_reset();
        check("R3 rcall push", 32'(push_o), 1);
        tick(); check("R3 rcall tgt", 32'(pc_o), 33); check("R3 rcall flush", 32'(flush_o), 1);
        tick(); check("R6 ret pop", 32'(pop_o), 1); check("R12 ret s=0", 32'(fast_o), 0);
        tick(); check("R6 ret pc", 32'(pc_o), 1); check("R6 ret flush", 32'(flush_o), 1);
    endtask

    // R4/R12: two-word call with fast bit, two-word jump
    task automatic t_two_word();
        clear_mem();
        mem[0] = 16'hED34; mem[1] = 16'hF001; mem[52] = 16'h0013;
        do_reset();
        check("R4 first word no push", 32'(push_o), 0);
        tick(); check("R4 second word pc", 32'(pc_o), 1); check("R4 no bubble", 32'(flush_o), 0);
        check("R4 call push", 32'(push_o), 1); check("R12 call fast", 32'(fast_o), 1);
        tick(); check("R4 call target", 32'(pc_o), 32'h134); check("R4 call flush", 32'(flush_o), 0);
        check("R12 ret fast", 32'(fast_o), 1); check("R6 ret pop", 32'(pop_o), 1);
        tick(); check("R4 return addr", 32'(pc_o), 2);
        clear_mem();
        mem[0] = 16'hEF40; mem[1] = 16'hF000;
        do_reset(); tick();
        check("R4 goto no push", 32'(push_o), 0);
        tick(); check("R4 goto target", 32'(pc_o), 32'h40); check("R4 goto no flush", 32'(flush_o), 0);
    endtask

    // R5: lone second-word pattern
    task automatic t_lone_f();
        clear_mem(); mem[0] = 16'hFABC;
        do_reset();
        check("R5 no strobe", 32'({push_o, pop_o, fast_o, sleep_o, wreg_ld_o}), 0);
        tick(); check("R5 pc+1", 32'(pc_o), 1); check("R5 no flush", 32'(flush_o), 0);
    endtask

    // R6/R7/R12: literal return and interrupt return
    task automatic t_retlw_retfie();
        clear_mem(); mem[0] = 16'hD810; mem[17] = 16'h0CA5;
        do_reset(); tick(); tick();
        check("R7 wreg load", 32'(wreg_ld_o), 1); check("R7 literal", 32'(wreg_val_o), 8'hA5);
        check("R7 pop", 32'(pop_o), 1);
        tick(); check("R7 pc", 32'(pc_o), 1); check("R7 flush", 32'(flush_o), 1);
        mem[17] = 16'h0011;
        do_reset(); tick(); tick();
        check("R6 gie", 32'(gie_set_o), 1); check("R12 retfie fast", 32'(fast_o), 1);
        tick(); check("R6 retfie pc", 32'(pc_o), 1);
    endtask

    // R8: explicit push and pop
    task automatic t_push_pop();
        clear_mem();
        mem[0] = 16'h0005; mem[1] = 16'h0005; mem[2] = 16'h0006; mem[3] = 16'h0012;
        do_reset();
        check("R8 push", 32'(push_o), 1);
        tick(); check("R8 push pc+1", 32'(pc_o), 1); check("R8 push no flush", 32'(flush_o), 0);
        tick(); check("R8 pop", 32'(pop_o), 1);
        tick(); tick(); check("R8 top after pop", 32'(pc_o), 1);
    endtask

    // R9: saturation at both ends
    task automatic t_bounds();
        clear_mem();
        for (int i = 0; i < 5; i++) mem[i] = 16'h0005;
        mem[5] = 16'h0012;
        do_reset();
        repeat (4) tick();
        check("R9 ovf", 32'(stk_ovf_o), 1); check("R9 refused push", 32'(push_o), 0);
        tick(); tick(); check("R9 top unchanged", 32'(pc_o), 4);
        clear_mem(); mem[0] = 16'h0006; mem[1] = 16'h0012;
        do_reset();
        check("R9 unf", 32'(stk_unf_o), 1); check("R9 refused pop", 32'(pop_o), 0);
        tick(); check("R9 unf ret", 32'(stk_unf_o), 1);
        tick(); check("R9 empty returns 0", 32'(pc_o), 0); check("R9 flush", 32'(flush_o), 1);
    endtask

    // R10/R11: power strobes and software reset emptying the stack
    task automatic t_power_reset();
        clear_mem();
        mem[0] = 16'hE009; mem[1] = 16'h0005; mem[2] = 16'h0003;
        mem[3] = 16'h0004; mem[4] = 16'h00FF; mem[10] = 16'h0012;
        z_i = 0; do_reset();
        tick(); tick();
        check("R10 sleep", 32'(sleep_o), 1);
        tick(); check("R10 wdt", 32'(wdt_clr_o), 1); check("R10 pc+1", 32'(pc_o), 3);
        tick(); check("R11 strobe", 32'(soft_rst_o), 1);
        tick(); check("R11 pc 0", 32'(pc_o), 0); check("R11 flush", 32'(flush_o), 1);
        z_i = 1;
        tick(); tick(); check("R2 bz taken", 32'(pc_o), 10);
        tick(); check("R11 stack emptied", 32'(stk_unf_o), 1);
        z_i = 0;
    endtask

    initial begin
        t_reset();
        t_cond_all();
        t_neg_offsets();
        t_rcall_ret();
        t_two_word();
        t_lone_f();
        t_retlw_retfie();
        t_push_pop();
        t_bounds();
        t_power_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule